// File: doc/BRIEF.md
# Disk Data FIFO Pair with Threshold Service Requests

This block sits between a host sequencer and a disk serialiser and buffers 16-bit words in both directions. The outbound queue carries words from the host towards the disk. The inbound queue carries words from the disk back to the host. Each queue shows its oldest word on a combinational read port and gives up that word on a pop strobe.

Each queue drives a service request for the host task that serves it. The inbound request means that at least four words are waiting. The outbound request means that at least four slots are free. Host strobes take effect on a request only two clock cycles after they are sampled. Queue accesses re-arm the request, the block strobe disarms it, and the empty-wait strobe holds the outbound request off. This two-cycle skew lets the host loops stay tight.

A clear strobe empties only the inbound queue and wipes the sticky error flags. Three errors are recorded. The disk can ask for a word that the outbound queue does not have (data-late). A push can arrive at a full queue, and the host can pop an empty inbound queue.

Top module: `disk_fifo_pair`

## Requirements
- R1: After reset both queues are empty, `out_drained` is 1, `out_req` is 1, `in_req` is 0, all three error flags are 0 and both read ports show 0.
- R2: Each queue returns words in push order. The read port shows the oldest word combinationally, and a pop moves the port to the next word.
- R3: `in_req` is 1 exactly when the inbound occupancy, as it stood two cycles earlier, is at least 4 and the inbound side is armed. A disk push or host pop sampled at edge k changes `in_req` only after edge k+2.
- R4: `out_req` is 1 exactly when the outbound free space, as it stood two cycles earlier, is at least 4, the outbound side is armed and no drain hold is active. A host push sampled at edge k changes `out_req` only after edge k+2.
- R5: A block strobe sampled at edge k disarms its own side, so that side's request is 0 after edge k+2. The other side is unaffected. A later host access on that side re-arms it: a push re-arms the outbound side and a pop re-arms the inbound side, with the same two-cycle delay. A block strobe and a re-arm that coincide leave the side disarmed.
- R6: An empty-wait strobe sampled at edge k forces `out_req` to 0 from edge k+2. The hold is released one edge after the delayed outbound occupancy reaches 0, so if the last word leaves at edge m, `out_req` is still 0 after edge m+2 and is 1 after edge m+3.
- R7: A disk pop while the outbound queue is empty reads 0 and sets `data_late` after that edge. The flag stays 1 until a clear strobe.
- R8: A clear strobe empties the inbound queue and drops any disk push in the same cycle. It also returns all three error flags to 0 after that edge. The outbound contents and `out_drained` are unchanged.
- R9: A host pop of an empty inbound queue reads 0, leaves the queue empty and sets the sticky `underflow` flag.
- R10: A push to a full queue is dropped, even if a pop happens in the same cycle. The dropped push leaves the stored words unchanged and sets the sticky `overflow` flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host pushes a word into the outbound queue |
| host_wr_data | input | 16 | Word pushed by the host |
| disk_rd_en | input | 1 | Disk pops the outbound queue |
| disk_rd_data | output | 16 | Oldest outbound word, 0 when empty |
| disk_wr_en | input | 1 | Disk pushes a word into the inbound queue |
| disk_wr_data | input | 16 | Word pushed by the disk |
| host_rd_en | input | 1 | Host pops the inbound queue |
| host_rd_data | output | 16 | Oldest inbound word, 0 when empty |
| out_block | input | 1 | Disarm the outbound service request |
| in_block | input | 1 | Disarm the inbound service request |
| out_drain_wait | input | 1 | Hold the outbound request until the queue drains |
| in_clear | input | 1 | Empty the inbound queue and clear error flags |
| out_req | output | 1 | Outbound service request |
| in_req | output | 1 | Inbound service request |
| out_drained | output | 1 | Outbound queue is empty now |
| data_late | output | 1 | Sticky: disk popped an empty outbound queue |
| overflow | output | 1 | Sticky: a push reached a full queue |
| underflow | output | 1 | Sticky: host popped an empty inbound queue |

## Verification
The read ports and `out_drained` respond in the same cycle as a pop or after the edge that moves a word. The bench checks the read ports before the edge and `out_drained` just after it. The error flags are due one edge after the event. Any request change caused by a strobe or a queue access sampled at edge k is due after edge k+2. The bench samples at the falling edge after k, k+1 and k+2, and checks that the old request value survives the first two samples and the new value appears at the third. For the drain release, the bench counts from the edge of the last pop and expects the request to stay low after edge m+2 and rise after edge m+3.

// File: rtl/dfp_pkg.sv
package dfp_pkg;
    localparam int WORD_W    = 16;
    localparam int Q_DEPTH   = 16;
    localparam int REQ_LEVEL = 4;
    localparam int STROBE_LAG = 2;

    typedef struct packed {
        logic late;
        logic ovf;
        logic udf;
    } err_flags_t;
endpackage

// File: rtl/dfp_queue.sv
module dfp_queue #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic [CW-1:0]    count_o,
    output logic             drop_o,
    output logic             starve_o
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wp;
        logic [AW-1:0]               rp;
        logic [CW-1:0]               cnt;
    } q_state_t;

    q_state_t st_d, st_q;
    logic     full, empty, take, give;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d  = st_q;
        full  = (st_q.cnt == CW'(DEPTH));
        empty = (st_q.cnt == '0);
        take  = push_i && !full && !clr_i;
        give  = pop_i && !empty && !clr_i;
        if (clr_i) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (take) begin
                st_d.mem[st_q.wp] = wdata_i;
                st_d.wp           = bump(st_q.wp);
            end
            if (give) begin
                st_d.rp = bump(st_q.rp);
            end
            st_d.cnt = st_q.cnt + CW'(take) - CW'(give);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_o   = empty ? '0 : st_q.mem[st_q.rp];
    assign count_o  = st_q.cnt;
    assign drop_o   = push_i && full && !clr_i;
    assign starve_o = pop_i && empty && !clr_i;

    // R10: a refused push leaves a full queue full
    assert_drop_keeps_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !clr_i && count_o == CW'(DEPTH)) |=> (count_o == CW'(DEPTH)));

    // R9: popping an empty queue cannot make it non-empty without a push
    assert_starve_stays_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && count_o == '0) |=> (count_o == '0));
endmodule

// File: rtl/dfp_req_gate.sv
module dfp_req_gate #(
    parameter int LEVEL_MAX   = 16,
    parameter int THRESH      = 4,
    parameter int DELAY       = 2,
    parameter int RESET_LEVEL = 0,
    parameter bit HAS_DRAIN   = 1'b0,
    localparam int CW   = $clog2(LEVEL_MAX + 1),
    localparam int TAIL = DELAY - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] level_i,
    input  logic          block_i,
    input  logic          rearm_i,
    input  logic          drain_i,
    output logic          req_o
);
    typedef struct packed {
        logic [DELAY-1:0][CW-1:0] lvl;
        logic [DELAY-1:0]         blk;
        logic [DELAY-1:0]         rea;
        logic [DELAY-1:0]         drn;
        logic                     arm;
        logic                     hold;
    } gate_state_t;

    gate_state_t g_d, g_q, g_rst;

    always_comb begin
        g_rst      = '0;
        g_rst.lvl  = {DELAY{CW'(RESET_LEVEL)}};
        g_rst.arm  = 1'b1;
    end

    always_comb begin
        g_d        = g_q;
        g_d.lvl[0] = level_i;
        g_d.blk[0] = block_i;
        g_d.rea[0] = rearm_i;
        g_d.drn[0] = drain_i;
        for (int i = 1; i < DELAY; i++) begin
            g_d.lvl[i] = g_q.lvl[i-1];
            g_d.blk[i] = g_q.blk[i-1];
            g_d.rea[i] = g_q.rea[i-1];
            g_d.drn[i] = g_q.drn[i-1];
        end
        if (g_q.blk[TAIL]) begin
            g_d.arm = 1'b0;
        end else if (g_q.rea[TAIL]) begin
            g_d.arm = 1'b1;
        end
        if (HAS_DRAIN) begin
            if (g_q.drn[TAIL]) begin
                g_d.hold = 1'b1;
            end else if (g_q.lvl[TAIL] == CW'(LEVEL_MAX)) begin
                g_d.hold = 1'b0;
            end
        end else begin
            g_d.hold = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q <= g_rst;
        end else begin
            g_q <= g_d;
        end
    end

    assign req_o = g_q.arm && !g_q.hold && (g_q.lvl[TAIL] >= CW'(THRESH));

    // R5: a block strobe reaching the end of its lag silences the request
    assert_block_silences_R5: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.blk[TAIL] |=> !req_o);

    // R6: an empty-wait strobe reaching the end of its lag silences the request
    assert_drain_silences_R6: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.drn[TAIL] |=> !req_o);
endmodule

// File: rtl/disk_fifo_pair.sv
module disk_fifo_pair
    import dfp_pkg::*;
#(
    parameter int WIDTH  = WORD_W,
    parameter int DEPTH  = Q_DEPTH,
    parameter int THRESH = REQ_LEVEL,
    parameter int DELAY  = STROBE_LAG,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr_en,
    input  logic [WIDTH-1:0] host_wr_data,
    input  logic             disk_rd_en,
    output logic [WIDTH-1:0] disk_rd_data,
    input  logic             disk_wr_en,
    input  logic [WIDTH-1:0] disk_wr_data,
    input  logic             host_rd_en,
    output logic [WIDTH-1:0] host_rd_data,
    input  logic             out_block,
    input  logic             in_block,
    input  logic             out_drain_wait,
    input  logic             in_clear,
    output logic             out_req,
    output logic             in_req,
    output logic             out_drained,
    output logic             data_late,
    output logic             overflow,
    output logic             underflow
);
    logic [CW-1:0] out_level, in_level, out_free;
    logic          out_drop, out_starve, in_drop, in_starve;
    err_flags_t    err_d, err_q;

    dfp_queue #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_outq (
        .clk(clk), .rst_n(rst_n), .clr_i(1'b0),
        .push_i(host_wr_en), .wdata_i(host_wr_data), .pop_i(disk_rd_en),
        .head_o(disk_rd_data), .count_o(out_level),
        .drop_o(out_drop), .starve_o(out_starve)
    );

    dfp_queue #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_inq (
        .clk(clk), .rst_n(rst_n), .clr_i(in_clear),
        .push_i(disk_wr_en), .wdata_i(disk_wr_data), .pop_i(host_rd_en),
        .head_o(host_rd_data), .count_o(in_level),
        .drop_o(in_drop), .starve_o(in_starve)
    );

    assign out_free = CW'(DEPTH) - out_level;

    dfp_req_gate #(.LEVEL_MAX(DEPTH), .THRESH(THRESH), .DELAY(DELAY),
                   .RESET_LEVEL(DEPTH), .HAS_DRAIN(1'b1)) u_out_gate (
        .clk(clk), .rst_n(rst_n), .level_i(out_free),
        .block_i(out_block), .rearm_i(host_wr_en), .drain_i(out_drain_wait),
        .req_o(out_req)
    );

    dfp_req_gate #(.LEVEL_MAX(DEPTH), .THRESH(THRESH), .DELAY(DELAY),
                   .RESET_LEVEL(0), .HAS_DRAIN(1'b0)) u_in_gate (
        .clk(clk), .rst_n(rst_n), .level_i(in_level),
        .block_i(in_block), .rearm_i(host_rd_en), .drain_i(1'b0),
        .req_o(in_req)
    );

    always_comb begin
        err_d = err_q;
        if (in_clear) begin
            err_d = '0;
        end else begin
            err_d.late = err_q.late | out_starve;
            err_d.ovf  = err_q.ovf | out_drop | in_drop;
            err_d.udf  = err_q.udf | in_starve;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= err_d;
        end
    end

    assign out_drained = (out_level == '0);
    assign data_late   = err_q.late;
    assign overflow    = err_q.ovf;
    assign underflow   = err_q.udf;

    // R7: data-late is raised by a starved disk pop and then held
    assert_late_on_starve_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (disk_rd_en && out_drained && !in_clear) |=> data_late);
    assert_late_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_late && !in_clear) |=> data_late);

    // R8: the clear strobe empties the inbound queue and wipes the flags
    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_clear |=> (in_level == '0 && !data_late && !overflow && !underflow));
endmodule

// File: tb/disk_fifo_pair_test.sv
module disk_fifo_pair_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 0, disk_rd_en = 0, disk_wr_en = 0, host_rd_en = 0;
    logic [15:0] host_wr_data = 0, disk_wr_data = 0;
    logic        out_block = 0, in_block = 0, out_drain_wait = 0, in_clear = 0;
    logic [15:0] disk_rd_data, host_rd_data;
    logic        out_req, in_req, out_drained, data_late, overflow, underflow;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    disk_fifo_pair uut (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .disk_rd_en(disk_rd_en), .disk_rd_data(disk_rd_data),
        .disk_wr_en(disk_wr_en), .disk_wr_data(disk_wr_data),
        .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
        .out_block(out_block), .in_block(in_block),
        .out_drain_wait(out_drain_wait), .in_clear(in_clear),
        .out_req(out_req), .in_req(in_req), .out_drained(out_drained),
        .data_late(data_late), .overflow(overflow), .underflow(underflow)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // one rising edge, then quiet strobes at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        host_wr_en = 0; disk_rd_en = 0; disk_wr_en = 0; host_rd_en = 0;
        out_block = 0; in_block = 0; out_drain_wait = 0; in_clear = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        step(); step();
        rst_n = 1;
    endtask

    task automatic host_push(input logic [15:0] w);
        host_wr_en = 1; host_wr_data = w; step();
    endtask

    task automatic disk_push(input logic [15:0] w);
        disk_wr_en = 1; disk_wr_data = w; step();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 out_req", out_req, 1);
        chk("R1 in_req", in_req, 0);
        chk("R1 drained", out_drained, 1);
        chk("R1 flags", {data_late, overflow, underflow}, 0);
        chk("R1 read ports", {disk_rd_data, host_rd_data}, 0);
    endtask

    task automatic t_order();
        do_reset();
        host_push(16'hA001); host_push(16'hA002); host_push(16'hA003);
        disk_push(16'h5101); disk_push(16'h5102);
        for (int i = 1; i <= 3; i++) begin
            chk("R2 outbound order", disk_rd_data, 32'hA000 + i);
            disk_rd_en = 1; step();
        end
        chk("R2 outbound emptied", out_drained, 1);
        for (int i = 1; i <= 2; i++) begin
            chk("R2 inbound order", host_rd_data, 32'h5100 + i);
            host_rd_en = 1; step();
        end
        chk("R2 no spurious flags", {data_late, overflow, underflow}, 0);
    endtask

    task automatic t_in_thresh();
        do_reset();
        for (int i = 0; i < 3; i++) disk_push(16'(i));
        step(); step();
        chk("R3 three words no req", in_req, 0);
        disk_push(16'h0003);
        chk("R3 after k", in_req, 0);
        step();
        chk("R3 after k+1", in_req, 0);
        step();
        chk("R3 after k+2", in_req, 1);
        host_rd_en = 1; step();
        chk("R3 pop after p", in_req, 1);
        step();
        chk("R3 pop after p+1", in_req, 1);
        step();
        chk("R3 pop after p+2", in_req, 0);
    endtask

    task automatic t_out_thresh();
        do_reset();
        for (int i = 0; i < 12; i++) host_push(16'(i));
        step(); step();
        chk("R4 four free", out_req, 1);
        host_push(16'h00CC);
        step();
        chk("R4 after k+1", out_req, 1);
        step();
        chk("R4 after k+2", out_req, 0);
        disk_rd_en = 1; step();
        step();
        chk("R4 pop after p+1", out_req, 0);
        step();
        chk("R4 pop after p+2", out_req, 1);
    endtask

    task automatic t_block();
        do_reset();
        for (int i = 0; i < 6; i++) disk_push(16'(i));
        step(); step();
        chk("R5 in armed", in_req, 1);
        in_block = 1; step();
        chk("R5 block after k", in_req, 1);
        step();
        chk("R5 block after k+1", in_req, 1);
        step();
        chk("R5 block after k+2", in_req, 0);
        chk("R5 other side untouched", out_req, 1);
        step(); step();
        chk("R5 stays disarmed", in_req, 0);
        host_rd_en = 1; step();
        step();
        chk("R5 rearm after p+1", in_req, 0);
        step();
        chk("R5 rearm after p+2", in_req, 1);
        in_block = 1; host_rd_en = 1; step();
        step(); step(); step();
        chk("R5 block beats rearm", in_req, 0);
        out_block = 1; step(); step(); step();
        chk("R5 out block", out_req, 0);
        host_push(16'h0001); step(); step();
        chk("R5 out rearm by push", out_req, 1);
    endtask

    task automatic t_drain();
        do_reset();
        for (int i = 0; i < 8; i++) host_push(16'(i));
        step(); step();
        chk("R6 before wait", out_req, 1);
        out_drain_wait = 1; step();
        step();
        chk("R6 wait after k+1", out_req, 1);
        step();
        chk("R6 wait after k+2", out_req, 0);
        for (int i = 0; i < 8; i++) begin
            disk_rd_en = 1; step();
        end
        chk("R6 drained now", out_drained, 1);
        chk("R6 held after m", out_req, 0);
        step(); step();
        chk("R6 held after m+2", out_req, 0);
        step();
        chk("R6 released after m+3", out_req, 1);
    endtask

    task automatic t_late();
        do_reset();
        disk_rd_en = 1;
        #1;
        chk("R7 empty read is zero", disk_rd_data, 0);
        step();
        chk("R7 late set", data_late, 1);
        host_push(16'h0042); step(); step();
        chk("R7 late sticky", data_late, 1);
        chk("R7 no other flags", {overflow, underflow}, 0);
    endtask

    task automatic t_clear();
        do_reset();
        disk_rd_en = 1; step();
        host_push(16'hBEE1); host_push(16'hBEE2);
        disk_push(16'h1111); disk_push(16'h2222); disk_push(16'h3333);
        chk("R8 late before clear", data_late, 1);
        in_clear = 1; disk_wr_en = 1; disk_wr_data = 16'h4444; step();
        chk("R8 flags cleared", data_late, 0);
        chk("R8 outbound kept", disk_rd_data, 16'hBEE1);
        chk("R8 outbound not drained", out_drained, 0);
        chk("R8 inbound empty", host_rd_data, 0);
        step(); step();
        chk("R8 no inbound req", in_req, 0);
        host_rd_en = 1; step();
        chk("R8 pop after clear underflows", underflow, 1);
    endtask

    task automatic t_underflow();
        do_reset();
        host_rd_en = 1;
        #1;
        chk("R9 empty pop reads zero", host_rd_data, 0);
        step();
        chk("R9 underflow set", underflow, 1);
        disk_push(16'h7777);
        chk("R9 queue still usable", host_rd_data, 16'h7777);
        step();
        chk("R9 underflow sticky", underflow, 1);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 0; i < 16; i++) host_push(16'h0C00 + 16'(i));
        chk("R10 no flag at full", overflow, 0);
        host_push(16'hDEAD);
        chk("R10 overflow set", overflow, 1);
        host_wr_en = 1; host_wr_data = 16'hFACE; disk_rd_en = 1; step();
        chk("R10 push+pop at full dropped", overflow, 1);
        for (int i = 1; i < 16; i++) begin
            chk("R10 stored word", disk_rd_data, 32'h0C00 + i);
            disk_rd_en = 1; step();
        end
        chk("R10 dropped words absent", out_drained, 1);
    endtask

    initial begin
        t_reset();
        t_order();
        t_in_thresh();
        t_out_thresh();
        t_block();
        t_drain();
        t_late();
        t_clear();
        t_underflow();
        t_overflow();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule